// File: doc/BRIEF.md
# Addressed Two-Wire Slave Front End with Write-Busy Hold-Off

This block is the serial receive front end for a device that holds two digitally controlled resistors. It watches a two-wire bus (clock line and open-drain data line), oversamples both lines with the system clock and detects START and STOP conditions. After a START, the first byte is an identification byte. It is compared against a fixed 4-bit device type and the levels on four address pins. On a full match the block pulls the data line low during the ninth clock as an acknowledge. On a mismatch it stays silent until the next START.

The second byte is an instruction byte. The block acknowledges it and splits it into an opcode, a data-register pointer and a wiper select. These fields appear on parallel outputs together with a one-cycle strobe. Any further bytes in the same transaction are acknowledged but not decoded. An instruction that commands a nonvolatile write, followed by a STOP on a byte boundary, starts an internal busy period whose length is a parameter. During that period the block ignores the bus entirely, so a master can poll by sending the identification byte until it is acknowledged again.

Top module: `dcr_serial_slave`

## Requirements
- R1: After reset the acknowledge drive `sda_oe_o`, the strobe `instr_valid_o` and `busy_o` are all low.
- R2: An identification byte is acknowledged when its bits [7:4] equal 4'b0101 and its bits [3:0] equal `addr_pins_i`. The acknowledge is `sda_oe_o` high, asserted while SCL is low after the eighth bit and released after the ninth SCL falling edge.
- R3: An identification byte that differs in either nibble gets no acknowledge, and no later byte in that transaction is acknowledged or decoded.
- R4: After the acknowledge of the instruction byte, `instr_valid_o` pulses for exactly one cycle. With it, `opcode_o` = bits [7:4], `dreg_sel_o` = bits [3:2] (0 selects register 0 through 3 selects register 3) and `wiper_sel_o` = bit [0]. Bit [1] is ignored.
- R5: The instruction byte and every further byte of a matched transaction are acknowledged.
- R6: If the instruction opcode is one of the nonvolatile write codes (defaults 4'b1100 and 4'b1000) and a STOP follows on a byte boundary, `busy_o` rises within a few cycles and stays high for `BUSY_CYCLES` clocks.
- R7: While `busy_o` is high, no byte is acknowledged and no strobe is produced, even for a matching identification byte.
- R8: Once the busy period has ended, a matching identification byte is acknowledged again.
- R9: A START or STOP in the middle of a byte aborts the transaction. No strobe is produced, no busy period starts, and the next START begins a new identification byte.
- R10: A STOP after an instruction whose opcode is not a nonvolatile write code does not start a busy period.
- R11: A repeated START after a complete instruction restarts identification, so a mismatching identification byte after it gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| addr_pins_i | input | 4 | Board-strapped slave address |
| sda_oe_o | output | 1 | High pulls the data line low (acknowledge) |
| busy_o | output | 1 | Internal nonvolatile write period in progress |
| instr_valid_o | output | 1 | One-cycle strobe for a decoded instruction |
| opcode_o | output | 4 | Decoded opcode field |
| dreg_sel_o | output | 2 | Data register pointer |
| wiper_sel_o | output | 1 | Wiper / resistor select |

## Verification
The identification path is driven with a matching byte, a byte with a wrong type nibble, a byte with a wrong pin nibble, and a match after the pins are re-strapped. This separates the two halves of the comparison. Instruction bytes sweep all four pointer values with both wiper settings, with bit 1 toggled and with trailing data bytes. Nonvolatile and ordinary opcodes are each followed by a STOP, and a poll inside and after the busy window tells the hold-off apart from a plain missing acknowledge. Aborts by STOP and by START in mid-byte, and a repeated START into a wrong address, show that the receiver restarts cleanly at byte boundaries only.

// File: rtl/dcr_slave_pkg.sv
package dcr_slave_pkg;

   localparam int BYTE_BITS = 8;
   localparam int NIB_W     = 4;
   localparam int DREG_W    = 2;

   localparam logic [NIB_W-1:0] DEVICE_TYPE = 4'b0101;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_SKIP
   } eng_state_t;

   typedef struct packed {
      logic [NIB_W-1:0]  opcode;
      logic [DREG_W-1:0] dreg;
      logic              wiper;
   } instr_t;

endpackage

// File: rtl/dcr_line_sync.sv
module dcr_line_sync #(
   parameter int   STAGES    = 2,
   parameter bit   FILTER_EN = 1'b0,
   parameter logic IDLE_VAL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{IDLE_VAL}};
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   generate
      if (FILTER_EN) begin : g_filter
         logic [1:0] hist;
         logic       q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hist <= {2{IDLE_VAL}};
               q_r  <= IDLE_VAL;
            end else begin
               hist <= {hist[0], chain[STAGES-1]};
               if (hist == 2'b11 && chain[STAGES-1])       q_r <= 1'b1;
               else if (hist == 2'b00 && !chain[STAGES-1]) q_r <= 1'b0;
            end
         end
         assign q_o = q_r;
      end else begin : g_plain
         assign q_o = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/dcr_cond_detect.sv
module dcr_cond_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s_i,
   input  logic sda_s_i,
   output logic start_o,
   output logic stop_o,
   output logic rise_o,
   output logic fall_o
);

   logic scl_p;
   logic sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s_i;
         sda_p <= sda_s_i;
      end
   end

   always_comb begin
      start_o = scl_s_i && scl_p && sda_p && !sda_s_i;
      stop_o  = scl_s_i && scl_p && !sda_p && sda_s_i;
      rise_o  = scl_s_i && !scl_p;
      fall_o  = !scl_s_i && scl_p;
   end

endmodule

// File: rtl/dcr_busy_timer.sv
module dcr_busy_timer #(
   parameter int BUSY_CYCLES = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic busy_o
);

   localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BUSY_CYCLES);

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               remain <= '0;
      else if (load_i)          remain <= LOAD_VAL;
      else if (remain != '0)    remain <= remain - 1'b1;
   end

   assign busy_o = (remain != '0);

endmodule

// File: rtl/dcr_byte_engine.sv
module dcr_byte_engine
   import dcr_slave_pkg::*;
#(
   parameter logic [NIB_W-1:0] TYPE_CODE = DEVICE_TYPE,
   parameter logic [NIB_W-1:0] NVW_OP_A  = 4'b1100,
   parameter logic [NIB_W-1:0] NVW_OP_B  = 4'b1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             rise_i,
   input  logic             fall_i,
   input  logic             sda_i,
   input  logic [NIB_W-1:0] addr_i,
   output logic             sda_oe_o,
   output logic             valid_o,
   output instr_t           instr_o,
   output logic             nv_load_o
);

   localparam int CNT_W = $clog2(BYTE_BITS + 1);
   localparam logic [CNT_W-1:0] FULL  = CNT_W'(BYTE_BITS);
   localparam logic [CNT_W-1:0] FIRST = CNT_W'(1);
   localparam logic [1:0]       LAST_IDX = 2'd2;

   eng_state_t             state;
   logic [CNT_W-1:0]       bit_cnt;
   logic [1:0]             byte_idx;
   logic [BYTE_BITS-1:0]   shreg;
   logic                   pend;
   logic                   nv_armed;
   logic                   id_hit;
   logic                   is_nvw;
   instr_t                 decoded;

   always_comb begin
      id_hit         = (shreg[BYTE_BITS-1 -: NIB_W] == TYPE_CODE) &&
                       (shreg[NIB_W-1:0] == addr_i);
      decoded.opcode = shreg[BYTE_BITS-1 -: NIB_W];
      decoded.dreg   = shreg[3:2];
      decoded.wiper  = shreg[0];
      is_nvw         = (decoded.opcode == NVW_OP_A) || (decoded.opcode == NVW_OP_B);
   end

   // A STOP always follows one SCL rise, so a boundary STOP sees exactly one counted bit.
   assign nv_load_o = stop_i && !busy_i && (state == ST_RX) &&
                      (bit_cnt == FIRST) && nv_armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         byte_idx <= '0;
         shreg    <= '0;
         sda_oe_o <= 1'b0;
         valid_o  <= 1'b0;
         pend     <= 1'b0;
         nv_armed <= 1'b0;
         instr_o  <= '0;
      end else begin
         valid_o <= 1'b0;
         if (busy_i) begin
            state    <= ST_IDLE;
            sda_oe_o <= 1'b0;
            pend     <= 1'b0;
            nv_armed <= 1'b0;
         end else if (start_i) begin
            state    <= ST_RX;
            bit_cnt  <= '0;
            byte_idx <= '0;
            sda_oe_o <= 1'b0;
            pend     <= 1'b0;
            nv_armed <= 1'b0;
         end else if (stop_i) begin
            state    <= ST_IDLE;
            sda_oe_o <= 1'b0;
            pend     <= 1'b0;
            nv_armed <= 1'b0;
         end else begin
            unique case (state)
               ST_RX: begin
                  if (rise_i && bit_cnt != FULL) begin
                     shreg   <= {shreg[BYTE_BITS-2:0], sda_i};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (fall_i && bit_cnt == FULL) begin
                     unique case (byte_idx)
                        2'd0: begin
                           if (id_hit) begin
                              state    <= ST_ACK;
                              sda_oe_o <= 1'b1;
                           end else begin
                              state <= ST_SKIP;
                           end
                        end
                        2'd1: begin
                           state    <= ST_ACK;
                           sda_oe_o <= 1'b1;
                           instr_o  <= decoded;
                           pend     <= 1'b1;
                           nv_armed <= is_nvw;
                        end
                        default: begin
                           state    <= ST_ACK;
                           sda_oe_o <= 1'b1;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (fall_i) begin
                     state    <= ST_RX;
                     sda_oe_o <= 1'b0;
                     bit_cnt  <= '0;
                     valid_o  <= pend;
                     pend     <= 1'b0;
                     if (byte_idx != LAST_IDX) byte_idx <= byte_idx + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/dcr_serial_slave.sv
module dcr_serial_slave
   import dcr_slave_pkg::*;
#(
   parameter int               SYNC_STAGES = 2,
   parameter bit               FILTER_EN   = 1'b0,
   parameter int               BUSY_CYCLES = 500000,
   parameter logic [NIB_W-1:0] TYPE_CODE   = DEVICE_TYPE,
   parameter logic [NIB_W-1:0] NVW_OP_A    = 4'b1100,
   parameter logic [NIB_W-1:0] NVW_OP_B    = 4'b1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [NIB_W-1:0]  addr_pins_i,
   output logic              sda_oe_o,
   output logic              busy_o,
   output logic              instr_valid_o,
   output logic [NIB_W-1:0]  opcode_o,
   output logic [DREG_W-1:0] dreg_sel_o,
   output logic              wiper_sel_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("BUSY_CYCLES must be at least 1");
      end
   endgenerate

   logic   scl_s;
   logic   sda_s;
   logic   start_det;
   logic   stop_det;
   logic   scl_rise;
   logic   scl_fall;
   logic   nv_load;
   instr_t instr;

   dcr_line_sync #(.STAGES(SYNC_STAGES), .FILTER_EN(FILTER_EN), .IDLE_VAL(1'b1)) u_sync_scl (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (scl_i),
      .q_o   (scl_s)
   );

   dcr_line_sync #(.STAGES(SYNC_STAGES), .FILTER_EN(FILTER_EN), .IDLE_VAL(1'b1)) u_sync_sda (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (sda_i),
      .q_o   (sda_s)
   );

   dcr_cond_detect u_cond (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_s_i (scl_s),
      .sda_s_i (sda_s),
      .start_o (start_det),
      .stop_o  (stop_det),
      .rise_o  (scl_rise),
      .fall_o  (scl_fall)
   );

   dcr_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (nv_load),
      .busy_o (busy_o)
   );

   dcr_byte_engine #(
      .TYPE_CODE (TYPE_CODE),
      .NVW_OP_A  (NVW_OP_A),
      .NVW_OP_B  (NVW_OP_B)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy_i    (busy_o),
      .start_i   (start_det),
      .stop_i    (stop_det),
      .rise_i    (scl_rise),
      .fall_i    (scl_fall),
      .sda_i     (sda_s),
      .addr_i    (addr_pins_i),
      .sda_oe_o  (sda_oe_o),
      .valid_o   (instr_valid_o),
      .instr_o   (instr),
      .nv_load_o (nv_load)
   );

   assign opcode_o    = instr.opcode;
   assign dreg_sel_o  = instr.dreg;
   assign wiper_sel_o = instr.wiper;

endmodule

// File: rtl/dcr_serial_slave_chk.sv
module dcr_serial_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic start_det,
   input logic stop_det,
   input logic sda_oe_o,
   input logic busy_o,
   input logic instr_valid_o
);

   AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !sda_oe_o); // R7

   AST_NO_STROBE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !instr_valid_o); // R7

   AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid_o |=> !instr_valid_o); // R4

   AST_ACK_DRIVEN_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !scl_s); // R2

   AST_ACK_RELEASED_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sda_oe_o) && !$past(start_det) && !$past(stop_det) && !busy_o) |-> !scl_s); // R5

   AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(stop_det)); // R6

endmodule

bind dcr_serial_slave dcr_serial_slave_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .scl_s         (scl_s),
   .start_det     (start_det),
   .stop_det      (stop_det),
   .sda_oe_o      (sda_oe_o),
   .busy_o        (busy_o),
   .instr_valid_o (instr_valid_o)
);

// File: tb/test_dcr_serial_slave.sv
module test_dcr_serial_slave;

   localparam int CLK_PERIOD = 10;
   localparam int H          = 8;
   localparam int BUSY       = 1500;
   localparam int SLACK      = 12;
   localparam int WATCHDOG   = 150000;

   typedef struct packed {
      logic [3:0] op;
      logic [1:0] dr;
      logic       w;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [3:0] pins = 4'h3;
   logic       sda_line;
   logic       sda_oe;
   logic       busy;
   logic       ivalid;
   logic [3:0] opc;
   logic [1:0] dreg;
   logic       wsel;

   int   compared   = 0;
   int   mismatched = 0;
   int   cyc        = 0;
   int   busy_start = -1;
   bit   model_nv   = 1'b0;
   bit   done       = 1'b0;
   exp_t exp_q[$];

   assign sda_line = sda_m & ~sda_oe;

   dcr_serial_slave #(.BUSY_CYCLES(BUSY)) i_dcr_serial_slave (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_i         (scl_m),
      .sda_i         (sda_line),
      .addr_pins_i   (pins),
      .sda_oe_o      (sda_oe),
      .busy_o        (busy),
      .instr_valid_o (ivalid),
      .opcode_o      (opc),
      .dreg_sel_o    (dreg),
      .wiper_sel_o   (wsel)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(bit ok, string req, string what, int act, int expv);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
      end
   endtask

   function automatic bit busy_now();
      return (busy_start >= 0) && (cyc < busy_start + BUSY);
   endfunction

   function automatic bit id_ok(logic [7:0] id);
      return (id[7:4] == 4'b0101) && (id[3:0] == pins) && !busy_now();
   endfunction

   // per-clock reference comparison
   int   since_v;
   exp_t got_v;
   exp_t want_v;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (busy_start < 0) begin
            check(busy == 1'b0, "R10", "busy with no write pending", busy, 0);
         end else begin
            since_v = cyc - busy_start;
            if (since_v >= SLACK && since_v < BUSY)
               check(busy == 1'b1, "R6", "busy inside write window", busy, 1);
            else if (since_v >= BUSY + SLACK)
               check(busy == 1'b0, "R8", "busy after write window", busy, 0);
         end
         if (ivalid) begin
            got_v = '{op: opc, dr: dreg, w: wsel};
            if (exp_q.size() == 0) begin
               check(1'b0, "R4", "unexpected instruction strobe", int'(got_v), -1);
            end else begin
               want_v = exp_q.pop_front();
               check(got_v == want_v, "R4", "decoded fields {op,dr,w}", int'(got_v), int'(want_v));
            end
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      if (!scl_m) begin
         sda_m = 1'b1; tick(H);
         scl_m = 1'b1; tick(H);
      end
      sda_m = 1'b0; tick(H);
      scl_m = 1'b0; tick(H);
      model_nv = 1'b0;
   endtask

   task automatic bus_stop(bit boundary);
      sda_m = 1'b0; tick(H);
      scl_m = 1'b1; tick(H);
      sda_m = 1'b1;
      if (boundary && model_nv && !busy_now()) busy_start = cyc;
      model_nv = 1'b0;
      tick(H);
   endtask

   task automatic send_bit(logic b);
      sda_m = b;    tick(H);
      scl_m = 1'b1; tick(H);
      scl_m = 1'b0; tick(H);
   endtask

   task automatic send_byte(logic [7:0] b, bit exp_ack, string req);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; tick(H);
      scl_m = 1'b1; tick(H/2);
      check(sda_line == !exp_ack, req, "acknowledge on ninth clock (1=ack)", !sda_line, exp_ack);
      tick(H - H/2);
      scl_m = 1'b0; tick(H);
   endtask

   task automatic command(logic [7:0] id, logic [7:0] ins, int ndata, string req);
      bit hit;
      hit = id_ok(id);
      bus_start();
      send_byte(id, hit, req);
      if (hit) begin
         exp_q.push_back('{op: ins[7:4], dr: ins[3:2], w: ins[0]});
      end
      send_byte(ins, hit, req);
      if (hit) model_nv = (ins[7:4] == 4'b1100) || (ins[7:4] == 4'b1000);
      for (int d = 0; d < ndata; d++) send_byte(8'hA5 ^ 8'(d), hit, "R5");
   endtask

   task automatic wait_idle();
      while (busy_now() || (busy_start >= 0 && cyc < busy_start + BUSY + SLACK)) tick(1);
      tick(SLACK);
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         compared++;
         mismatched++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, WATCHDOG);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin : stimulus
      tick(5);
      rst_n = 1'b1;
      tick(3);
      // R1 reset state
      check(sda_oe == 1'b0, "R1", "ack drive after reset", sda_oe, 0);
      check(ivalid == 1'b0, "R1", "strobe after reset", ivalid, 0);
      check(busy == 1'b0, "R1", "busy after reset", busy, 0);

      // R2/R4/R10: matching id, ordinary opcode, bit 1 set (ignored)
      command(8'h53, 8'b1001_1011, 0, "R2");
      bus_stop(1);
      tick(SLACK);
      check(busy == 1'b0, "R10", "busy after ordinary opcode", busy, 0);

      // R3: wrong type nibble, then wrong pin nibble
      command(8'h73, 8'b1100_0100, 0, "R3");
      bus_stop(1);
      command(8'h5C, 8'b1100_0100, 1, "R3");
      bus_stop(1);

      // R2: re-strapped pins
      pins = 4'hA;
      tick(2);
      command(8'h5A, 8'b0010_0001, 0, "R2");
      bus_stop(1);

      // R4/R5: all pointer values, both wipers, with data bytes
      for (int p = 0; p < 4; p++) begin
         command(8'h5A, {4'b0011, 2'(p), 1'b0, 1'(p)}, 2, "R4");
         bus_stop(1);
      end

      // R6/R7/R8: nonvolatile write, poll during busy, poll after
      command(8'h5A, 8'b1100_0110, 1, "R6");
      bus_stop(1);
      bus_start();
      send_byte(8'h5A, id_ok(8'h5A), "R7");
      bus_stop(1);
      command(8'h5A, 8'b1001_0101, 0, "R7");
      bus_stop(1);
      wait_idle();
      bus_start();
      send_byte(8'h5A, 1'b1, "R8");
      bus_stop(1);

      // R6: second nonvolatile opcode, no data byte
      command(8'h5A, 8'b1000_1001, 0, "R6");
      bus_stop(1);
      tick(SLACK + 4);
      check(busy == 1'b1, "R6", "busy after second write code", busy, 1);
      wait_idle();

      // R9: STOP mid-byte during a nonvolatile instruction
      bus_start();
      send_byte(8'h5A, 1'b1, "R9");
      send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
      bus_stop(0);
      tick(SLACK + 4);
      check(busy == 1'b0, "R9", "busy after mid-byte stop", busy, 0);

      // R9: START mid-byte, then a fresh transaction
      bus_start();
      send_byte(8'h5A, 1'b1, "R9");
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
      command(8'h5A, 8'b0110_1100, 0, "R9");
      bus_stop(1);

      // R11: repeated start after an instruction into a wrong address
      command(8'h5A, 8'b0101_0111, 0, "R11");
      command(8'h5B, 8'b0101_0111, 0, "R11");
      bus_stop(1);

      tick(4 * H);
      check(exp_q.size() == 0, "R4", "strobes still owed", exp_q.size(), 0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule